// File: doc/BRIEF.md
# Register-Stack LRU Tracker

This block keeps the exact recency order of the ways of a single cache set. The order is held as a chain of way-ID registers. Position 0 holds the most recently used way and position NUM_WAYS-1 holds the least recently used way. The controlling cache reports each access to a way with a one-cycle strobe and the way's ID. The block then reorders the chain and presents the bottom entry as the way to evict on the next miss.

When a way is referenced, the entries from the top down to the slot that holds that way each move one place toward the bottom. Entries below that slot stay where they are. The top slot then takes the referenced ID, so the referenced way moves to the top.

The whole reorder takes one clock edge. Every position of the chain can be read on a flat output bus. The block covers one set only: the cache around it supplies the tags, the data arrays, hit detection and set indexing.

Top module: `lru_regstack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, position p holds way ID p for every p. The victim is therefore way NUM_WAYS-1.
- R2: `victim_way` always equals the entry at the bottom position, NUM_WAYS-1. `order_flat` shows every position, with position p in bits [p*ID_W +: ID_W]; position 0 is the most recently used.
- R3: In the cycle after a strobe with `ref_valid`=1, position 0 holds the referenced `ref_way`.
- R4: On a strobe, let k be the position that held `ref_way`. Every entry at a position below k keeps its value. Every entry at positions 0 to k-1 moves to the next position down. The old entry of position k-1 therefore lands in position k.
- R5: A strobe whose `ref_way` already sits at position 0 leaves the whole order unchanged.
- R6: While `ref_valid` is 0, the order does not change, whatever value `ref_way` has.
- R7: The chain always holds each way ID from 0 to NUM_WAYS-1 exactly once.
- R8: Each strobe is applied in full on the clock edge that samples it. Strobes on consecutive cycles are each applied, in order, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_valid | input | 1 | Strobe: a way was referenced this cycle |
| ref_way | input | ID_W | ID of the referenced way |
| victim_way | output | ID_W | Least recently used way, the entry at the bottom position |
| order_flat | output | NUM_WAYS*ID_W | Full recency order; position p in bits [p*ID_W +: ID_W] |

## Verification
The bench goes after four cases:
- A reference to the way already at the top. A design that shifts anyway would duplicate an ID or move the victim.
- A reference to the bottom way. The whole chain must move down, and a design that stops one slot early would leave a stale victim.
- A reference to a middle way. A design that shifts past the matching slot would corrupt the entries below it.
- Idle cycles with a changing `ref_way`, followed by long runs of back-to-back strobes.

Every result is compared with an order list kept in the bench, which rebuilds the list as "new ID first, then the old list without it". The bench also checks on every result that the order is still a permutation of all way IDs.

// File: rtl/lru_stack_pkg.sv
package lru_stack_pkg;

  // Number of bits needed to name one way of the set.
  function automatic int unsigned way_id_bits(input int unsigned ways);
    return (ways <= 2) ? 1 : $clog2(ways);
  endfunction

  // Way ID that a stack position holds after reset: identity order.
  function automatic int unsigned reset_way_at(input int unsigned pos);
    return pos;
  endfunction

endpackage

// File: rtl/lru_match_scan.sv
// Compares every stack position with the referenced ID and reports, for each
// position, whether no position above it held the ID.
module lru_match_scan #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned ID_W     = 2
) (
  input  logic [NUM_WAYS*ID_W-1:0] order_flat,
  input  logic [ID_W-1:0]          ref_way,
  output logic [NUM_WAYS-1:0]      match_vec,
  output logic [NUM_WAYS-1:0]      clear_above,
  output logic                     found
);

  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_cmp
    assign match_vec[p] = (order_flat[p*ID_W +: ID_W] == ref_way);
  end

  // clear_above[p] = 1 when positions 0..p-1 all differ from ref_way
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int p = 0; p < NUM_WAYS; p++) begin
      clear_above[p] = ~seen;
      seen = seen | match_vec[p];
    end
  end

  assign found = |match_vec;

endmodule

// File: rtl/lru_stack_slot.sv
// One register of the recency chain.
module lru_stack_slot #(
  parameter int unsigned ID_W     = 2,
  parameter int unsigned RESET_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] d,
  output logic [ID_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= ID_W'(RESET_ID);
    else if (load) q <= d;
  end

endmodule

// File: rtl/lru_regstack.sv
module lru_regstack
  import lru_stack_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned ID_W     = way_id_bits(NUM_WAYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_valid,
  input  logic [ID_W-1:0]          ref_way,
  output logic [ID_W-1:0]          victim_way,
  output logic [NUM_WAYS*ID_W-1:0] order_flat
);

  localparam int unsigned ORDER_W = NUM_WAYS * ID_W;
  localparam int unsigned BOT     = NUM_WAYS - 1;

  // Internal events, named for the checker
  logic [NUM_WAYS-1:0] match_vec;
  logic [NUM_WAYS-1:0] clear_above;
  logic                found;
  logic [NUM_WAYS-1:0] load_vec;
  logic [ORDER_W-1:0]  stack_q;

  lru_match_scan #(.NUM_WAYS(NUM_WAYS), .ID_W(ID_W)) u_scan (
    .order_flat (stack_q),
    .ref_way    (ref_way),
    .match_vec  (match_vec),
    .clear_above(clear_above),
    .found      (found)
  );

  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_slot
    logic [ID_W-1:0] slot_d;
    if (p == 0) begin : g_top
      // Top takes the new ID unless it already holds it
      assign load_vec[p] = ref_valid & found & clear_above[p] & ~match_vec[p];
      assign slot_d      = ref_way;
    end else begin : g_mid
      // Shift down from above while no upper position held the ID
      assign load_vec[p] = ref_valid & found & clear_above[p];
      assign slot_d      = stack_q[(p-1)*ID_W +: ID_W];
    end
    lru_stack_slot #(.ID_W(ID_W), .RESET_ID(reset_way_at(p))) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_vec[p]),
      .d    (slot_d),
      .q    (stack_q[p*ID_W +: ID_W])
    );
  end

  assign order_flat = stack_q;
  assign victim_way = stack_q[BOT*ID_W +: ID_W];

endmodule

// File: rtl/lru_regstack_chk.sv
module lru_regstack_chk #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned ID_W     = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ref_valid,
  input logic [ID_W-1:0]          ref_way,
  input logic [ID_W-1:0]          victim_way,
  input logic [NUM_WAYS*ID_W-1:0] order_flat,
  input logic [NUM_WAYS-1:0]      match_vec,
  input logic [NUM_WAYS-1:0]      load_vec
);

  localparam int unsigned SEEN_W = 1 << ID_W;

  logic [SEEN_W-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM_WAYS; p++) seen[order_flat[p*ID_W +: ID_W]] = 1'b1;
  end

  // R7: every way ID present once
  p_permutation_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_WAYS);

  // R7: exactly one position matches any referenced ID
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> $countones(match_vec) == 1);

  // R3
  p_top_is_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> order_flat[ID_W-1:0] == $past(ref_way));

  // R5
  p_top_ref_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && order_flat[ID_W-1:0] == ref_way) |=> $stable(order_flat));

  // R6
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> $stable(order_flat));

  // R4: bottom holds unless it was the referenced way
  p_bottom_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_way != victim_way) |=> $stable(victim_way));

  // R4: referencing the bottom pulls the next-to-bottom entry down
  p_bottom_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_way == victim_way && order_flat[ID_W-1:0] != ref_way) |=>
      victim_way == $past(order_flat[(NUM_WAYS-2)*ID_W +: ID_W]));

  // R2
  p_victim_bottom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way == order_flat[(NUM_WAYS-1)*ID_W +: ID_W]);

  // R4: loads form a contiguous run from the top
  for (genvar p = 1; p < NUM_WAYS; p++) begin : g_prefix
    p_load_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[p] |-> load_vec[p-1]);
  end

endmodule

bind lru_regstack lru_regstack_chk #(.NUM_WAYS(NUM_WAYS), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_valid (ref_valid),
  .ref_way   (ref_way),
  .victim_way(victim_way),
  .order_flat(order_flat),
  .match_vec (match_vec),
  .load_vec  (load_vec)
);

// File: tb/lru_regstack_bench.sv
`timescale 1ns/1ps
module lru_regstack_bench;
  localparam int N   = 4;
  localparam int IDW = $clog2(N);
  localparam int OW  = N * IDW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0;
  logic [IDW-1:0] ref_way = '0;
  logic [IDW-1:0] victim_way;
  logic [OW-1:0]  order_flat;

  always #4 clk = ~clk;

  lru_regstack #(.NUM_WAYS(N)) u_lru_regstack (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_way(ref_way),
    .victim_way(victim_way), .order_flat(order_flat)
  );

  int checks = 0;
  int errors = 0;
  int mdl[N];
  logic [OW-1:0] exp_q[$];
  string         tag_q[$];

  function automatic logic [OW-1:0] pack_model();
    logic [OW-1:0] r;
    for (int p = 0; p < N; p++) r[p*IDW +: IDW] = IDW'(mdl[p]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_perm(input string tag);
    logic [N-1:0] seen;
    seen = '0;
    for (int p = 0; p < N; p++) seen[order_flat[p*IDW +: IDW]] = 1'b1;
    check(tag, 32'(seen), 32'((1 << N) - 1));
  endtask

  // Driver: strobe one way and push the expected order
  task automatic touch(input int w, input string tag);
    int nxt[N];
    int k;
    @(negedge clk);
    ref_valid = 1'b1;
    ref_way   = IDW'(w);
    nxt[0] = w;
    k = 1;
    for (int p = 0; p < N; p++)
      if (mdl[p] != w) begin nxt[k] = mdl[p]; k++; end
    mdl = nxt;
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int w, input string tag);
    @(negedge clk);
    ref_valid = 1'b0;
    ref_way   = IDW'(w);
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
  endtask

  // Monitor: compare each result away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [OW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " order"}, 32'(order_flat), 32'(e));
        check({t, "/R2 victim"}, 32'(victim_way), 32'(e[(N-1)*IDW +: IDW]));
        check_perm({t, "/R7 permutation"});
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic [OW-1:0] rst_exp;
    for (int p = 0; p < N; p++) begin
      mdl[p] = p;
      rst_exp[p*IDW +: IDW] = IDW'(p);
    end
    repeat (3) @(negedge clk);
    check("R1 order in reset", 32'(order_flat), 32'(rst_exp));
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 order after reset", 32'(order_flat), 32'(rst_exp));
    check("R1 victim after reset", 32'(victim_way), 32'(N - 1));

    touch(0, "R5 top ref");
    touch(N - 1, "R3 bottom ref");
    touch(1, "R4 middle ref");
    touch(1, "R5 repeat top ref");
    idle(2, "R6 idle");
    idle(0, "R6 idle");
    idle(3, "R6 idle");
    // back-to-back reference stream
    touch(2, "R8 stream"); touch(1, "R8 stream"); touch(3, "R8 stream");
    touch(0, "R8 stream"); touch(3, "R8 stream"); touch(2, "R8 stream");
    touch(1, "R8 stream");
    idle(1, "R6 idle after stream");
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[7:6] == 2'b00) idle(int'(lfsr[IDW-1:0]), "R6 random idle");
      else touch(int'(lfsr[IDW-1:0]), "R4 random ref");
    end
    @(negedge clk);
    ref_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule